// File: doc/BRIEF.md
# Endian-Selectable Data Lane Aligner

This block sits between a load/store unit and a 64-bit data memory port. For each data access it takes the byte offset inside the doubleword, the access size (1, 2, 4 or 8 bytes), a per-instruction little-endian request and a per-page little-endian attribute from the translation unit. From these it produces the byte-lane enables and the store data placed in the right lanes. For loads it returns the selected bytes right-justified, in the chosen byte order, and sign- or zero-extended to 64 bits.

The two little-endian inputs combine by exclusive OR. Each one therefore inverts the other, and with neither set the data is big-endian. Instruction fetch does not pass through this block, so the instruction stream stays big-endian whatever the data settings are. The request path, from request to enables and store data, has no registers. The load return path has one register stage. An access whose offset is not a multiple of its size only raises a flag: the block drives no enables for it.

Top module: `ldst_lane_aligner`

## Requirements
- R1: While rst_ni is low, and on the first clock after it, ld_valid_o and ld_data_o are zero, even if a load is requested.
- R2: For an aligned valid access, mem_be_o sets exactly size bytes. Offset k maps to bit 7-k, so offset 0 is the most significant lane, bits 63:56.
- R3: When (offset mod size) is not zero, align_err_o is 1, mem_be_o and mem_wdata_o are zero, and the access produces no load return.
- R4: For a big-endian store, the most significant byte of the right-justified value goes to the lowest addressed lane. All lanes outside the access read zero.
- R5: When exactly one of insn_le_i and page_le_i is 1, a store places the value's least significant byte at the lowest addressed lane.
- R6: When insn_le_i and page_le_i are both 1, the access behaves exactly as big-endian.
- R7: A valid aligned load gives ld_valid_o on the next clock. ld_data_o then holds the accessed bytes right-justified, with the lowest address as the most significant byte when the data is big-endian.
- R8: A little-endian load returns the byte at the lowest address in bits 7:0 of ld_data_o.
- R9: When req_signed_i is 1, bits above the access width copy the top bit of the value. When it is 0, those bits are zero.
- R10: With req_valid_i low, mem_be_o is 0, mem_wdata_o is 0 and align_err_o is 0, and no load return follows.
- R11: A store request, aligned or not, never produces ld_valid_o on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_off_i | input | 3 | Byte offset inside the doubleword |
| req_size_i | input | 2 | log2 of the access size in bytes |
| req_signed_i | input | 1 | Sign-extend the load result |
| insn_le_i | input | 1 | Little-endian request carried by the instruction |
| page_le_i | input | 1 | Little-endian attribute of the page |
| st_data_i | input | 64 | Right-justified store value |
| mem_be_o | output | 8 | Byte-lane enables, bit 7 = offset 0 |
| mem_wdata_o | output | 64 | Store data placed in its lanes |
| align_err_o | output | 1 | Misaligned access flag |
| mem_rdata_i | input | 64 | Doubleword read for the current load |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 64 | Aligned and extended load result |

## Verification
The bench builds the block with its default 64-bit data width and 3-bit offset. That makes all four access sizes reachable, and every offset can be checked against each size, including the full doubleword, where no extension bits are left. Under that width, directed cases cover each combination of the two little-endian inputs and both extension modes. A run of random accesses then reaches misaligned halfword, word and doubleword offsets, and it also covers a store that follows a load.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  function automatic int size_bytes(input logic [1:0] sz);
    return 1 << sz;
  endfunction
endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
  parameter int NB    = 8,
  parameter int OFF_W = 3
) (
  input  logic             valid_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [NB-1:0]    be_o,
  output logic             err_o,
  output logic             ok_o
);
  import aligner_pkg::*;

  always_comb begin
    int n;
    int o;
    n     = size_bytes(size_i);
    o     = int'(off_i);
    err_o = valid_i && ((o % n) != 0);
    ok_o  = valid_i && !err_o;
    for (int l = 0; l < NB; l++) begin
      be_o[l] = ok_o && ((NB - 1 - l) >= o) && ((NB - 1 - l) < o + n);
    end
  end
endmodule

// File: rtl/store_lane_mux.sv
module store_lane_mux #(
  parameter int NB    = 8,
  parameter int OFF_W = 3
) (
  input  logic             ok_i,
  input  logic             le_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic [8*NB-1:0]  data_i,
  output logic [8*NB-1:0]  wdata_o
);
  import aligner_pkg::*;

  for (genvar l = 0; l < NB; l++) begin : g_lane
    logic [7:0] lane_b;
    always_comb begin
      int a;
      int n;
      int o;
      int j;
      a      = NB - 1 - l;
      n      = size_bytes(size_i);
      o      = int'(off_i);
      j      = le_i ? (a - o) : (o + n - 1 - a);
      lane_b = 8'h00;
      if (ok_i && a >= o && a < o + n) lane_b = data_i[8*j +: 8];
    end
    assign wdata_o[8*l +: 8] = lane_b;
  end
endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract #(
  parameter int NB    = 8,
  parameter int OFF_W = 3
) (
  input  logic             le_i,
  input  logic             signed_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic [8*NB-1:0]  rdata_i,
  output logic [8*NB-1:0]  value_o
);
  import aligner_pkg::*;

  logic [NB-1:0][7:0] raw;

  for (genvar b = 0; b < NB; b++) begin : g_pick
    always_comb begin
      int n;
      int o;
      int a;
      n      = size_bytes(size_i);
      o      = int'(off_i);
      a      = le_i ? (o + b) : (o + n - 1 - b);
      raw[b] = 8'h00;
      if (b < n && a >= 0 && a < NB) raw[b] = rdata_i[8*(NB-1-a) +: 8];
    end
  end

  always_comb begin
    int   n;
    logic fill;
    n    = size_bytes(size_i);
    fill = signed_i && raw[n-1][7];
    for (int b = 0; b < NB; b++) begin
      value_o[8*b +: 8] = (b < n) ? raw[b] : {8{fill}};
    end
  end
endmodule

// File: rtl/ldst_lane_aligner.sv
module ldst_lane_aligner #(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic              insn_le_i,
  input  logic              page_le_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              align_err_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o
);
  // one toggles order, both cancel
  logic le_eff;
  logic acc_ok;
  logic ld_take;
  logic [DATA_W-1:0] ld_val;
  logic [DATA_W-1:0] ld_data_q;
  logic              ld_valid_q;

  assign le_eff = insn_le_i ^ page_le_i;

  lane_mask_gen #(.NB(NB), .OFF_W(OFF_W)) u_mask (
    .valid_i (req_valid_i),
    .off_i   (req_off_i),
    .size_i  (req_size_i),
    .be_o    (mem_be_o),
    .err_o   (align_err_o),
    .ok_o    (acc_ok)
  );

  store_lane_mux #(.NB(NB), .OFF_W(OFF_W)) u_st (
    .ok_i    (acc_ok),
    .le_i    (le_eff),
    .off_i   (req_off_i),
    .size_i  (req_size_i),
    .data_i  (st_data_i),
    .wdata_o (mem_wdata_o)
  );

  load_lane_extract #(.NB(NB), .OFF_W(OFF_W)) u_ld (
    .le_i     (le_eff),
    .signed_i (req_signed_i),
    .off_i    (req_off_i),
    .size_i   (req_size_i),
    .rdata_i  (mem_rdata_i),
    .value_o  (ld_val)
  );

  assign ld_take = acc_ok && !req_store_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_q <= 1'b0;
      ld_data_q  <= '0;
    end else begin
      ld_valid_q <= ld_take;
      if (ld_take) ld_data_q <= ld_val;
    end
  end

  assign ld_valid_o = ld_valid_q;
  assign ld_data_o  = ld_data_q;
endmodule

// File: rtl/aligner_chk.sv
module aligner_chk #(
  parameter int NB    = 8,
  parameter int OFF_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_store_i,
  input logic [OFF_W-1:0] req_off_i,
  input logic [1:0]       req_size_i,
  input logic [NB-1:0]    mem_be_o,
  input logic             align_err_o,
  input logic             ld_valid_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!ld_valid_o);
  end

  assert_be_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !align_err_o) |-> ($countones(mem_be_o) == (1 << req_size_i)));

  assert_err_no_be_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> (mem_be_o == '0));

  assert_err_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ((int'(req_off_i) % (1 << req_size_i)) != 0)) |-> align_err_o);

  assert_ld_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $past(req_valid_i && !req_store_i && !align_err_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (mem_be_o == '0 && !align_err_o));

  assert_store_no_ld_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i) |=> !ld_valid_o);
endmodule

bind ldst_lane_aligner aligner_chk #(.NB(NB), .OFF_W(OFF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_store_i (req_store_i),
  .req_off_i   (req_off_i),
  .req_size_i  (req_size_i),
  .mem_be_o    (mem_be_o),
  .align_err_o (align_err_o),
  .ld_valid_o  (ld_valid_o)
);

// File: tb/sim_ldst_lane_aligner.sv
`timescale 1ns/1ps
module sim_ldst_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, store = 1'b0, sgn = 1'b0, ile = 1'b0, ple = 1'b0;
  logic [2:0]  off = '0;
  logic [1:0]  sz = '0;
  logic [63:0] st = '0, rd = '0;
  logic [7:0]  be;
  logic [63:0] wd, ldd;
  logic        err, ldv;

  int total = 0;
  int bad = 0;
  logic        pend_v = 1'b0;
  logic [63:0] pend_d = '0;
  string       pend_tag = "R7";

  always #4 clk = ~clk;

  ldst_lane_aligner u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_store_i(store),
    .req_off_i(off), .req_size_i(sz), .req_signed_i(sgn), .insn_le_i(ile),
    .page_le_i(ple), .st_data_i(st), .mem_be_o(be), .mem_wdata_o(wd),
    .align_err_o(err), .mem_rdata_i(rd), .ld_valid_o(ldv), .ld_data_o(ldd)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory image view: address a sits in lane 7-a
  task automatic step(input logic v, input logic s, input int o, input int z, input logic il,
                      input logic pl, input logic sg, input logic [63:0] sd, input logic [63:0] rdd,
                      input string tag);
    int n;
    logic le, e;
    logic [7:0]  ebe;
    logic [63:0] ewd, eld;
    byte unsigned m[8];
    @(negedge clk);
    check(ldv == pend_v, pend_tag, {63'd0, ldv}, {63'd0, pend_v});
    if (pend_v) check(ldd == pend_d, pend_tag, ldd, pend_d);
    valid = v; store = s; off = 3'(o); sz = 2'(z); ile = il; ple = pl; sgn = sg; st = sd; rd = rdd;
    n = 1 << z;
    le = il ^ pl;
    e = v && (o % n != 0);
    ebe = '0; ewd = '0; eld = '0;
    for (int a = 0; a < 8; a++) m[a] = rdd[8*(7-a) +: 8];
    if (v && !e) begin
      for (int k = 0; k < n; k++) begin
        int idx;
        idx = le ? k : n - 1 - k;
        ebe[7-(o+k)] = 1'b1;
        ewd[8*(7-(o+k)) +: 8] = sd[8*idx +: 8];
        eld[8*idx +: 8] = m[o+k];
      end
      if (sg && eld[8*n-1] && n < 8) eld = eld | (~64'd0 << (8*n));
    end
    #1;
    check(be == ebe, tag, {56'd0, be}, {56'd0, ebe});
    check(err == e, tag, {63'd0, err}, {63'd0, e});
    check(wd == ewd, tag, wd, ewd);
    pend_v = v && !e && !s;
    pend_d = eld;
    pend_tag = s ? "R11" : (e ? "R3" : (v ? tag : "R10"));
  endtask

  initial begin
    #1_600_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    valid = 1'b1; store = 1'b0; sz = 2'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(ldv == 1'b0, "R1", {63'd0, ldv}, 64'd0);
    check(ldd == 64'd0, "R1", ldd, 64'd0);
    valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(ldv == 1'b0, "R1", {63'd0, ldv}, 64'd0);

    step(1, 1, 0, 3, 0, 0, 0, 64'h0102030405060708, 0, "R4");
    step(1, 1, 4, 2, 0, 0, 0, 64'h00000000AABBCCDD, 0, "R4");
    step(1, 1, 6, 1, 0, 0, 0, 64'h0000000000001234, 0, "R2");
    step(1, 1, 5, 0, 0, 0, 0, 64'h00000000000000EE, 0, "R2");
    step(1, 1, 4, 2, 1, 0, 0, 64'h00000000AABBCCDD, 0, "R5");
    step(1, 1, 2, 1, 0, 1, 0, 64'h0000000000001234, 0, "R5");
    step(1, 1, 0, 3, 1, 1, 0, 64'h0102030405060708, 0, "R6");
    step(1, 1, 2, 2, 0, 0, 0, 64'hFFFFFFFFFFFFFFFF, 0, "R3");
    step(1, 0, 3, 1, 1, 0, 0, 0, 64'h1122334455667788, "R3");
    step(0, 0, 0, 3, 0, 0, 0, 64'hFFFF, 64'h1122334455667788, "R10");
    step(1, 0, 0, 3, 0, 0, 0, 0, 64'h1122334455667788, "R7");
    step(1, 0, 4, 2, 0, 0, 0, 0, 64'h1122334455667788, "R7");
    step(1, 0, 4, 2, 1, 0, 0, 0, 64'h1122334455667788, "R8");
    step(1, 0, 6, 1, 0, 1, 0, 0, 64'h1122334455667788, "R8");
    step(1, 0, 0, 3, 1, 1, 0, 0, 64'h1122334455667788, "R6");
    step(1, 0, 1, 0, 0, 0, 1, 0, 64'h0080000000000000, "R9");
    step(1, 0, 1, 0, 0, 0, 0, 0, 64'h0080000000000000, "R9");
    step(1, 0, 0, 2, 1, 0, 1, 0, 64'h000000F000000000, "R9");
    step(1, 0, 2, 1, 0, 0, 1, 0, 64'h00007FFF00000000, "R9");
    step(1, 1, 0, 3, 0, 0, 0, 64'h55, 0, "R11");
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      step(1'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 4),
           1'($urandom), 1'($urandom), 1'($urandom), a, b, "R7");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule